// File: doc/BRIEF.md
# Daisy-Chain DAC Command Serializer

This block is a serial master for a string of identical digital-to-analog converters. Their serial inputs and outputs are wired in series, and they share one bit clock and one chip-select/load line. The host presents a 4-bit command and a 16-bit value for every position in the chain and pulses `start`. The master pulls the chip-select/load line low and clocks the whole chain's worth of 24-bit words into the first device's serial input. It then releases the line, and every converter acts on its own word at that same instant.

Each word goes out most significant bit first. The order is the command nibble, then a nibble of zeros, then the 16 data bits. The words are sent in reverse chain order. Because the data ripples down the string, the word shifted first ends up in the device farthest from the master. In single-target mode only the selected position receives the host's command and data. Every other position receives the no-operation command, so one converter can be changed without disturbing the rest.

The bit clock comes from the system clock through a parameterized divider, and it idles low. The serial data changes only on its falling edges, so the devices can sample on the rising edges. A `busy`/`done` pair tells the host when a frame is in flight and when it has been committed.

Top module: `dac_chain_master`

## Requirements
- R1: Each slot word is 24 bits, sent MSB first: bits 23..20 carry the command, bits 19..16 are 0 and bits 15..0 carry the data. Device i takes its command from `cmd_in[4*i+3:4*i]` and its data from `data_in[16*i+15:16*i]`.
- R2: The first word shifted is that of device N_DEV-1, and the last word shifted is that of device 0.
- R3: `sck` rises only while `cs_ld` is low. Each frame holds exactly N_DEV*24 rising edges of `sck`.
- R4: When `single` is 1, the slot selected by `target` carries that device's command and data. Every other slot carries command 4'b1111 with data 0.
- R5: `sck` is low whenever the block is idle. In a frame each `sck` high phase lasts exactly DIV clock cycles, and so does each low phase between two rising edges.
- R6: `sdi` does not change while `sck` is high.
- R7: `cs_ld` is low for at least DIV clock cycles before the first rising edge of `sck`. It stays low for at least DIV cycles after the last falling edge.
- R8: `busy` rises on the clock edge that samples `start`. `busy` falls on the same edge where `cs_ld` rises. `done` is high for exactly that one cycle.
- R9: A `start` sampled while `busy` is high is ignored, including on the edge that completes the frame. The frame in flight keeps the words latched at its start.
- R10: After reset `cs_ld`=1, `sck`=0, `sdi`=0, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| start | input | 1 | Frame request strobe |
| single | input | 1 | 1: address only the `target` position |
| target | input | IW | Chain position used when `single` is 1 |
| cmd_in | input | 4*N_DEV | Per-device command nibbles |
| data_in | input | 16*N_DEV | Per-device data values |
| sck | output | 1 | Shared bit clock |
| sdi | output | 1 | Serial data into the first device |
| cs_ld | output | 1 | Shared chip-select/load, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when `cs_ld` returns high |

## Verification
The clash of interest is a new `start` landing on the edge where the frame finishes. On that edge `done` pulses and `cs_ld` rises. The bench holds `start` high from the request through that completion edge. It then confirms that `cs_ld` stays high and `busy` stays low afterwards, with no second frame. A separate run changes the inputs and pulses `start` in the middle of a frame. The bench then compares the captured bit stream against the words latched at the first request.

// File: rtl/dac_chain_master.sv
module dac_chain_master #(
  parameter int N_DEV = 4,
  parameter int DIV   = 2,
  localparam int IW   = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 single,
  input  logic [IW-1:0]        target,
  input  logic [4*N_DEV-1:0]   cmd_in,
  input  logic [16*N_DEV-1:0]  data_in,
  output logic                 sck,
  output logic                 sdi,
  output logic                 cs_ld,
  output logic                 busy,
  output logic                 done
);
  localparam int FW = 24 * N_DEV;
  localparam int BW = $clog2(FW);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DIV - 1);
  localparam logic [BW-1:0] LAST   = BW'(FW - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TRAIL} state_t;

  state_t          state;
  logic [FW-1:0]   shreg, frame;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitcnt;

  always_comb begin
    for (int i = 0; i < N_DEV; i++) begin
      if (single && (target != IW'(i)))
        frame[24*i +: 24] = {4'hF, 4'h0, 16'h0000};
      else
        frame[24*i +: 24] = {cmd_in[4*i +: 4], 4'h0, data_in[16*i +: 16]};
    end
  end

  assign sdi = shreg[FW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      shreg  <= '0;
      cnt    <= '0;
      bitcnt <= '0;
      sck    <= 1'b0;
      cs_ld  <= 1'b1;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          shreg  <= frame;
          cs_ld  <= 1'b0;
          busy   <= 1'b1;
          cnt    <= RELOAD;
          bitcnt <= '0;
          state  <= S_SHIFT;
        end
        S_SHIFT: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= RELOAD;
          if (!sck) begin
            sck <= 1'b1;
          end else begin
            sck <= 1'b0;
            if (bitcnt == LAST) begin
              state <= S_TRAIL;
            end else begin
              shreg  <= shreg << 1;
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        S_TRAIL: if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cs_ld <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
          shreg <= '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r3_clock_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_ld);
  a_r5_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  a_r6_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(sdi));
  a_r8_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_ld) |-> (done && !busy));
  a_r9_no_restart_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_ld);
endmodule

// File: tb/tb_dac_chain_master.sv
`timescale 1ns/1ps
module tb_dac_chain_master;
  localparam int N   = 4;
  localparam int DIV = 2;
  localparam int IW  = (N > 1) ? $clog2(N) : 1;
  localparam int FW  = 24 * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, single = 1'b0;
  logic [IW-1:0] target = '0;
  logic [4*N-1:0] cmd_in = '0;
  logic [16*N-1:0] data_in = '0;
  logic sck, sdi, cs_ld, busy, done;

  int checks = 0, fails = 0, cycles = 0;

  dac_chain_master #(.N_DEV(N), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .single(single), .target(target),
    .cmd_in(cmd_in), .data_in(data_in), .sck(sck), .sdi(sdi), .cs_ld(cs_ld),
    .busy(busy), .done(done));

  always #2.5 clk = ~clk;

  // frame monitor
  logic [FW-1:0] cap;
  int nbits, run, lead, trail, per_err, sdi_err;
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_sdi = 1'b0, first;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_ld && prev_cs) begin
        nbits = 0; run = 1; first = 1'b1; per_err = 0; sdi_err = 0;
        lead = 0; trail = 0; cap = '0;
      end else if (!cs_ld) begin
        if (sck != prev_sck) begin
          if (sck) begin
            if (first) lead = run; else if (run != DIV) per_err++;
            first = 1'b0;
            cap = {cap[FW-2:0], sdi};
            nbits++;
          end else if (run != DIV) per_err++;
          run = 1;
        end else begin
          run++;
          if (sck && sdi != prev_sdi) sdi_err++;
        end
      end else if (!prev_cs) begin
        trail = run;
      end
    end
    prev_sck = sck; prev_cs = cs_ld; prev_sdi = sdi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] exp_frame(input logic sm, input logic [IW-1:0] tg,
      input logic [4*N-1:0] c, input logic [16*N-1:0] d);
    logic [FW-1:0] f;
    for (int i = 0; i < N; i++) begin
      if (sm && tg != IW'(i)) f[24*i +: 24] = {4'hF, 4'h0, 16'h0};
      else f[24*i +: 24] = {c[4*i +: 4], 4'h0, d[16*i +: 16]};
    end
    return f;
  endfunction

  task automatic run_frame(input logic sm, input logic [IW-1:0] tg,
      input logic [4*N-1:0] c, input logic [16*N-1:0] d, input bit poke, input bit hold);
    logic [FW-1:0] e;
    e = exp_frame(sm, tg, c, d);
    @(negedge clk);
    single = sm; target = tg; cmd_in = c; data_in = d; start = 1'b1;
    @(negedge clk);
    if (!hold) start = 1'b0;
    chk(busy && !cs_ld, "R8", "busy after start", {busy, cs_ld}, 2'b10);
    if (poke) begin
      repeat (60) @(negedge clk);
      cmd_in = ~c; data_in = ~d; single = ~sm; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(cs_ld && !busy, "R8", "release with done", {cs_ld, busy}, 2'b10);
    start = 1'b0;
    @(negedge clk);
    chk(!done, "R8", "done width", done, 0);
    chk(cap == e, sm ? "R4" : (poke ? "R9" : "R1 R2"), "frame bits", cap, e);
    chk(nbits == FW, "R3", "rising edges", nbits, FW);
    chk(lead >= DIV && trail >= DIV, "R7", "lead/trail", {lead[15:0], trail[15:0]}, DIV);
    chk(per_err == 0, "R5", "phase widths", per_err, 0);
    chk(sdi_err == 0, "R6", "sdi while high", sdi_err, 0);
    if (hold) begin
      repeat (6) begin
        @(negedge clk);
        chk(cs_ld && !busy && !sck, "R9", "no restart", {cs_ld, busy, sck}, 3'b100);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(cs_ld && !sck && !sdi && !busy && !done, "R10", "reset outputs",
        {cs_ld, sck, sdi, busy, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_ld && !sck && !busy, "R5", "idle", {cs_ld, sck, busy}, 3'b100);
    run_frame(1'b0, '0, {N{4'h3}}, {N{16'hFFFF}}, 1'b0, 1'b0);
    run_frame(1'b0, '0, '0, '0, 1'b0, 1'b0);
    run_frame(1'b0, '0, 16'h1234, 64'h0123_4567_89AB_CDEF, 1'b0, 1'b0);
    run_frame(1'b1, '0, {N{4'h2}}, {N{16'hA5A5}}, 1'b0, 1'b0);
    run_frame(1'b1, IW'(N-1), {N{4'h0}}, {N{16'h5A5A}}, 1'b0, 1'b0);
    for (int k = 0; k < 10; k++) begin
      logic [4*N-1:0] c;
      logic [16*N-1:0] d;
      c = {$urandom, $urandom}; d = {$urandom, $urandom, $urandom};
      run_frame(1'($urandom), IW'($urandom), c, d, 1'b0, 1'b0);
    end
    run_frame(1'b0, '0, 16'hBEEF, {N{16'h1357}}, 1'b1, 1'b0);
    run_frame(1'b0, '0, 16'h4C21, {N{16'h2468}}, 1'b0, 1'b1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule